// File: doc/BRIEF.md
# Ping-Pong Receive Buffer Ring Controller

This block takes received Ethernet frames from a MAC byte stream and stores each one in its own fixed-size buffer inside a ring in memory. Every buffer starts with a small status header that gives the stored length and the error flags. The payload follows the header. The controller holds two channel register sets. Each set has a base address, a remaining-buffer count and an armed state. The host can reload one set while the other one is filling. When the active set runs out of buffers, activity moves to the other set.

The host programs a set with the following sequence:
1. Write a load command.
2. Write the base address.
3. Write the buffer count.
4. Write the arm command.

The host may pause a set and read back how many buffers remain. A frame that completes raises a level interrupt. The interrupt stays high until the host writes a pause or arm command. A channel control word lets the host stop, start and fully reset the channel. Frames that arrive while nothing can take them are dropped whole and counted.

Top module: `rxr_dma_ring`

## Requirements
- R1: After reset, the following all read as zero: the control word, both sets' base, remaining count and armed bit, and the irq output. No memory write occurs until a frame is accepted.
- R2: An accepted frame's byte k (k counted from 0) is written alone to address base + idx*2^BUF_LOG2 + 16 + k. Here idx is the number of frames already stored by the active set since its count was last written.
- R3: After the payload, the header is written. Header byte 0 is the stored length bits 7:0. Header byte 2 holds the following: bit7 = truncation overflow, bits 6:4 = rx_err[2:0] sampled with the last byte, bits 3:0 = stored length bits 11:8.
- R4: Bytes beyond 2^BUF_LOG2 − 16 are not written. Such a frame stores exactly that many payload bytes, reports that length and sets the overflow bit.
- R5: Each stored frame lowers the set's remaining count by one. The count is read at set offset 0x8.
- R6: When a stored frame brings a set's remaining count to zero, that set disarms (command-offset read bit0 = 0). The active-set bit (control bit 4) then selects the other set, so the next frame goes to the other set's base.
- R7: A frame whose first byte arrives while the channel is not running or the active set is not armed causes no memory write. Such a frame increments the missed counter in control bits 31:24, which saturates at 255.
- R8: A stored frame sets the event bit (control bit 8, 0x0100) and raises irq. Writing command 0x1100 or 0x9800 to either set clears the event bit.
- R9: Command 0x1100 disarms a set and keeps its remaining count. Re-arming with 0x9800 resumes at the next unused buffer.
- R10: Arming a set whose remaining count is zero leaves it disarmed and sets the error bit (control bit 13, 0x2000) and irq. Control write 0x8800 clears error and event, stops the channel and selects set 0.
- R11: Control write 0x0400 starts the channel (control bit 0). Control write 0x1000 stops it.
- R12: Register map: set s at 0x10*s, with the following offsets: command at +0x0 (commands 0x0100 load/disarm, 0x9800 arm, 0x1100 pause; read bit0 = armed), base at +0x4, remaining count at +0x8. The control word is at 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 6 | Host register byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on host_addr) |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 3 | Collision, framing, FCS flags, valid with the last byte |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Level interrupt: event or error pending |

## Verification
The MAC stream has no back-pressure, so the header writes and the commit need idle cycles after each frame. The checks assume that rx_valid stays low while the header is written and while the commit pulse is high, which is two cycles after the last byte. The stimulus leaves six idle cycles after every frame, and it changes set registers only between frames. This keeps host writes from colliding with a commit. The event-clear check also excludes the cycle of a commit.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  localparam logic [15:0] CMD_LOAD    = 16'h0100;
  localparam logic [15:0] CMD_ARM     = 16'h9800;
  localparam logic [15:0] CMD_PAUSE   = 16'h1100;
  localparam logic [15:0] CTL_QUIESCE = 16'h8800;
  localparam logic [15:0] CTL_GO      = 16'h0400;
  localparam logic [15:0] CTL_OFF     = 16'h1000;
  localparam int HDR_BYTES = 16;
  localparam int LEN_W     = 12;
  localparam int MISS_W    = 8;

  typedef enum logic [1:0] {
    WS_BODY   = 2'd0,
    WS_HDR_LO = 2'd1,
    WS_HDR_ST = 2'd2
  } wr_st_e;

  typedef enum logic [1:0] {
    RG_CMD  = 2'd0,
    RG_BASE = 2'd1,
    RG_REM  = 2'd2,
    RG_NONE = 2'd3
  } set_reg_e;
endpackage

// File: rtl/rxr_set.sv
`timescale 1ns/1ps
module rxr_set
  import rxr_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_base,
  input  logic          we_rem,
  input  logic          we_cmd,
  input  logic [31:0]   wdata,
  input  logic          commit,
  output logic [AW-1:0] base_o,
  output logic [CW-1:0] rem_o,
  output logic [CW-1:0] idx_o,
  output logic          armed_o,
  output logic          bad_arm_o
);
  logic [AW-1:0] base_q, base_n;
  logic [CW-1:0] rem_q, rem_n, idx_q, idx_n;
  logic          armed_q, armed_n, bad_n;

  always_comb begin
    base_n  = base_q;
    rem_n   = rem_q;
    idx_n   = idx_q;
    armed_n = armed_q;
    bad_n   = 1'b0;
    if (commit) begin
      idx_n = idx_q + CW'(1);
      if (rem_q != '0) rem_n = rem_q - CW'(1);
      if (rem_q == CW'(1)) armed_n = 1'b0;
    end
    if (we_base) base_n = wdata[AW-1:0];
    if (we_rem) begin
      rem_n = wdata[CW-1:0];
      idx_n = '0;
    end
    if (we_cmd) begin
      case (wdata[15:0])
        CMD_LOAD, CMD_PAUSE: armed_n = 1'b0;
        CMD_ARM: begin
          if (rem_n != '0) armed_n = 1'b1;
          else begin
            armed_n = 1'b0;
            bad_n   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      base_q  <= base_n;
      rem_q   <= rem_n;
      idx_q   <= idx_n;
      armed_q <= armed_n;
    end
  end

  assign base_o    = base_q;
  assign rem_o     = rem_q;
  assign idx_o     = idx_q;
  assign armed_o   = armed_q;
  assign bad_arm_o = bad_n;

  AST_DRAIN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rem_q == CW'(1) && !we_rem && !we_cmd) |=> !armed_q); // R6
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rem_q != '0 && !we_rem) |=> (rem_q == $past(rem_q) - CW'(1))); // R5
  AST_ZERO_ARM_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_cmd && wdata[15:0] == CMD_ARM && rem_q == '0 && !we_rem) |=> !armed_q); // R10
endmodule

// File: rtl/rxr_wr.sv
`timescale 1ns/1ps
module rxr_wr
  import rxr_pkg::*;
#(
  parameter int AW       = 24,
  parameter int BUF_LOG2 = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [2:0]    rx_err,
  input  logic          accept_ok,
  input  logic [AW-1:0] frame_base,
  input  logic          act_set,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          commit_o,
  output logic          commit_set_o,
  output logic          miss_o
);
  localparam int BUF_BYTES = 1 << BUF_LOG2;
  localparam int PAY       = BUF_BYTES - HDR_BYTES;
  localparam logic [LEN_W-1:0] PAY_L = LEN_W'(PAY);

  wr_st_e           st_q, st_n;
  logic             in_q, in_n, keep_q, keep_n, ovf_q, ovf_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [3:0]       flg_q, flg_n;
  logic [AW-1:0]    fbase_q, fbase_n, addr_n;
  logic             fset_q, fset_n, we_n, commit_n, miss_n;
  logic [7:0]       data_n;

  logic             first, take;
  logic [AW-1:0]    base_sel;
  logic [LEN_W-1:0] cnt_cur;

  assign first    = !in_q;
  assign take     = first ? accept_ok : keep_q;
  assign base_sel = first ? frame_base : fbase_q;
  assign cnt_cur  = first ? '0 : cnt_q;

  always_comb begin
    st_n     = st_q;
    in_n     = in_q;
    keep_n   = keep_q;
    cnt_n    = cnt_q;
    ovf_n    = ovf_q;
    flg_n    = flg_q;
    fbase_n  = fbase_q;
    fset_n   = fset_q;
    we_n     = 1'b0;
    addr_n   = mem_addr;
    data_n   = mem_wdata;
    commit_n = 1'b0;
    miss_n   = 1'b0;
    case (st_q)
      WS_BODY: begin
        if (rx_valid) begin
          if (first) begin
            keep_n  = accept_ok;
            fbase_n = frame_base;
            fset_n  = act_set;
            cnt_n   = '0;
            ovf_n   = 1'b0;
          end
          if (take) begin
            if (cnt_cur < PAY_L) begin
              we_n   = 1'b1;
              addr_n = base_sel + AW'(HDR_BYTES) + AW'(cnt_cur);
              data_n = rx_data;
              cnt_n  = cnt_cur + LEN_W'(1);
            end else begin
              ovf_n = 1'b1;
            end
          end
          in_n = !rx_last;
          if (rx_last) begin
            if (take) begin
              st_n  = WS_HDR_LO;
              flg_n = {ovf_n, rx_err};
            end else begin
              miss_n = 1'b1;
            end
          end
        end
      end
      WS_HDR_LO: begin
        we_n   = 1'b1;
        addr_n = fbase_q;
        data_n = cnt_q[7:0];
        st_n   = WS_HDR_ST;
      end
      WS_HDR_ST: begin
        we_n     = 1'b1;
        addr_n   = fbase_q + AW'(2);
        data_n   = {flg_q, cnt_q[11:8]};
        commit_n = 1'b1;
        st_n     = WS_BODY;
      end
      default: st_n = WS_BODY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= WS_BODY;
      in_q      <= 1'b0;
      keep_q    <= 1'b0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      flg_q     <= '0;
      fbase_q   <= '0;
      fset_q    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      commit_o  <= 1'b0;
      miss_o    <= 1'b0;
    end else begin
      st_q      <= st_n;
      in_q      <= in_n;
      keep_q    <= keep_n;
      cnt_q     <= cnt_n;
      ovf_q     <= ovf_n;
      flg_q     <= flg_n;
      fbase_q   <= fbase_n;
      fset_q    <= fset_n;
      mem_we    <= we_n;
      mem_addr  <= addr_n;
      mem_wdata <= data_n;
      commit_o  <= commit_n;
      miss_o    <= miss_n;
    end
  end

  assign commit_set_o = fset_q;

  AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != WS_BODY || commit_o) |-> !rx_valid); // R2
  AST_WRITE_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr - fbase_q) < AW'(BUF_BYTES))); // R4
  AST_HDR_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_o) |-> (mem_we && mem_addr == fbase_q + AW'(2))); // R3
endmodule

// File: rtl/rxr_dma_ring.sv
`timescale 1ns/1ps
module rxr_dma_ring
  import rxr_pkg::*;
#(
  parameter int AW       = 24,
  parameter int CW       = 4,
  parameter int BUF_LOG2 = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [5:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [2:0]    rx_err,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          irq
);
  localparam int NSETS = 2;

  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [AW-1:0]   base_a [NSETS];
  logic [CW-1:0]   rem_a  [NSETS];
  logic [CW-1:0]   idx_a  [NSETS];
  logic [NSETS-1:0] armed_v, bad_v, commit_v;

  logic          set_wr, ctl_wr, ack_wr;
  logic          commit, commit_set, miss_p;
  logic [AW-1:0] frame_base;
  logic          run_q, run_n, act_q, act_n, evt_q, evt_n, err_q, err_n;
  logic [MISS_W-1:0] miss_q, miss_n;

  assign set_wr = host_wr && !host_addr[5];
  assign ctl_wr = host_wr && host_addr[5];
  assign ack_wr = set_wr && host_addr[3:2] == RG_CMD &&
                  (host_wdata[15:0] == CMD_PAUSE || host_wdata[15:0] == CMD_ARM);

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    assign commit_v[g] = commit && (commit_set == 1'(g));
    rxr_set #(.AW(AW), .CW(CW)) u_set (
      .clk       (clk),
      .rst_n     (rst_i),
      .we_base   (set_wr && host_addr[4] == 1'(g) && host_addr[3:2] == RG_BASE),
      .we_rem    (set_wr && host_addr[4] == 1'(g) && host_addr[3:2] == RG_REM),
      .we_cmd    (set_wr && host_addr[4] == 1'(g) && host_addr[3:2] == RG_CMD),
      .wdata     (host_wdata),
      .commit    (commit_v[g]),
      .base_o    (base_a[g]),
      .rem_o     (rem_a[g]),
      .idx_o     (idx_a[g]),
      .armed_o   (armed_v[g]),
      .bad_arm_o (bad_v[g])
    );
  end

  assign frame_base = base_a[act_q] + (AW'(idx_a[act_q]) << BUF_LOG2);

  rxr_wr #(.AW(AW), .BUF_LOG2(BUF_LOG2)) u_wr (
    .clk          (clk),
    .rst_n        (rst_i),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_last      (rx_last),
    .rx_err       (rx_err),
    .accept_ok    (run_q && armed_v[act_q]),
    .frame_base   (frame_base),
    .act_set      (act_q),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .commit_o     (commit),
    .commit_set_o (commit_set),
    .miss_o       (miss_p)
  );

  always_comb begin
    run_n  = run_q;
    act_n  = act_q;
    evt_n  = evt_q;
    err_n  = err_q;
    miss_n = miss_q;
    if (commit) begin
      evt_n = 1'b1;
      if (rem_a[commit_set] == CW'(1)) act_n = !commit_set;
    end
    if (|bad_v) err_n = 1'b1;
    if (ack_wr) evt_n = 1'b0;
    if (miss_p && miss_q != '1) miss_n = miss_q + MISS_W'(1);
    if (ctl_wr) begin
      case (host_wdata[15:0])
        CTL_QUIESCE: begin
          run_n = 1'b0;
          act_n = 1'b0;
          evt_n = 1'b0;
          err_n = 1'b0;
        end
        CTL_GO:  run_n = 1'b1;
        CTL_OFF: run_n = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      evt_q  <= 1'b0;
      err_q  <= 1'b0;
      miss_q <= '0;
    end else begin
      run_q  <= run_n;
      act_q  <= act_n;
      evt_q  <= evt_n;
      err_q  <= err_n;
      miss_q <= miss_n;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr[5]) begin
      host_rdata = {miss_q, 10'd0, err_q, 4'd0, evt_q, 3'd0, act_q, 3'd0, run_q};
    end else begin
      case (host_addr[3:2])
        RG_CMD:  host_rdata = {31'd0, armed_v[host_addr[4]]};
        RG_BASE: host_rdata = 32'(base_a[host_addr[4]]);
        RG_REM:  host_rdata = 32'(rem_a[host_addr[4]]);
        default: host_rdata = '0;
      endcase
    end
  end

  assign irq = evt_q || err_q;

  AST_ACK_DROPS_EVENT: assert property (@(posedge clk) disable iff (!rst_i)
    (ack_wr && !commit) |=> !evt_q); // R8
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_i)
    ((|bad_v) && !ctl_wr) |=> irq); // R10
endmodule

// File: tb/rxr_dma_ring_tb.sv
`timescale 1ns/1ps
module rxr_dma_ring_tb_top;
  localparam int AW = 12;
  localparam int PAYMAX = 16;
  localparam logic [15:0] ARM = 16'h9800, PAUSE = 16'h1100, LOAD = 16'h0100;
  localparam logic [5:0] CTL = 6'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [5:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic [2:0] rx_err = '0;
  logic mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0, n_bad = 0, wcount = 0;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  rxr_dma_ring #(.AW(AW), .CW(4), .BUF_LOG2(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq));

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    wcount <= wcount + 1;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 13 + k * 5 + 1) & 255);
  endfunction

  task automatic load_set(input int s, input int base, input int n);
    hw(6'(s * 16),     32'(LOAD));
    hw(6'(s * 16 + 4), 32'(base));
    hw(6'(s * 16 + 8), 32'(n));
    hw(6'(s * 16),     32'(ARM));
  endtask

  task automatic send(input int seed, input int len, input logic [2:0] e);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, k);
      rx_last = (k == len - 1); rx_err = (k == len - 1) ? e : 3'b0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_frame(input int base, input int len, input int seed,
                             input logic [2:0] e, input int w0);
    int st;
    logic ovf;
    st  = (len > PAYMAX) ? PAYMAX : len;
    ovf = (len > PAYMAX);
    chk("R3", "header length byte", mem[base], st);
    chk("R3", "header status byte", mem[base + 2], {ovf, e, 4'h0});
    for (int k = 0; k < st; k++)
      chk("R2", "payload byte", mem[base + 16 + k], pat(seed, k));
    chk(ovf ? "R4" : "R2", "write count", wcount - w0, st + 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w0, sn, b, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(CTL, d);   chk("R1", "control after reset", d, 0);
    rd(6'h08, d); chk("R1", "set0 remaining after reset", d, 0);
    rd(6'h10, d); chk("R1", "set1 armed after reset", d, 0);
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "writes after reset", wcount, 0);

    hw(CTL, 32'h8800);
    load_set(0, 32'h100, 8);
    load_set(1, 32'h400, 8);
    hw(CTL, 32'h0400);
    rd(CTL, d);   chk("R11", "running after start", d, 1);
    rd(6'h14, d); chk("R12", "set1 base readback", d, 32'h400);
    rd(6'h04, d); chk("R12", "set0 base readback", d, 32'h100);
    rd(6'h00, d); chk("R12", "set0 armed readback", d, 1);

    // sweep frame lengths 1..16 across both sets
    for (int i = 0; i < 16; i++) begin
      w0 = wcount;
      send(i, i + 1, 3'(i + 1));
      sn = i / 8; b = i % 8;
      base = (sn == 1 ? 32'h400 : 32'h100) + b * 32;
      check_frame(base, i + 1, i, 3'(i + 1), w0);
      rd(6'(sn * 16 + 8), d); chk("R5", "remaining count", d, 7 - b);
      chk("R8", "irq after frame", irq, 1);
      rd(CTL, d); chk("R8", "event bit", d[8], 1);
      if (i == 7 || i == 15) begin
        rd(CTL, d); chk("R6", "active set after drain", d[4], (i == 7) ? 1 : 0);
        rd(6'(sn * 16), d); chk("R6", "drained set disarmed", d[0], 0);
      end
      if (i < 15) hw(6'(((i + 1) / 8) * 16), 32'(ARM));
      else        hw(6'h10, 32'(PAUSE));
      chk("R8", "irq after acknowledge", irq, 0);
    end

    // both sets drained: frame dropped
    w0 = wcount;
    send(40, 5, 3'b0);
    chk("R7", "no writes when unarmed", wcount - w0, 0);
    rd(CTL, d); chk("R7", "missed count", d[31:24], 1);
    chk("R7", "irq stays low on drop", irq, 0);

    // reload set0, truncation sweep 17..20
    hw(CTL, 32'h8800);
    load_set(0, 32'h100, 8);
    hw(CTL, 32'h0400);
    for (int i = 0; i < 4; i++) begin
      w0 = wcount;
      send(20 + i, 17 + i, 3'(5 + i));
      check_frame(32'h100 + i * 32, 17 + i, 20 + i, 3'(5 + i), w0);
      hw(6'h00, 32'(ARM));
    end
    rd(6'h08, d); chk("R5", "remaining after truncated frames", d, 4);

    // pause and resume
    hw(6'h00, 32'(PAUSE));
    rd(6'h00, d); chk("R9", "paused set disarmed", d[0], 0);
    rd(6'h08, d); chk("R9", "pause keeps remaining", d, 4);
    w0 = wcount;
    send(50, 4, 3'b0);
    chk("R9", "no writes while paused", wcount - w0, 0);
    rd(CTL, d); chk("R7", "missed count while paused", d[31:24], 2);
    hw(6'h00, 32'(ARM));
    w0 = wcount;
    send(51, 3, 3'b010);
    check_frame(32'h100 + 4 * 32, 3, 51, 3'b010, w0);
    rd(6'h08, d); chk("R9", "remaining after resume", d, 3);
    hw(6'h00, 32'(ARM));

    // arming an empty set
    hw(6'h18, 32'd0);
    hw(6'h10, 32'(ARM));
    rd(CTL, d);   chk("R10", "error on empty arm", d, 32'h02002001);
    chk("R10", "irq on error", irq, 1);
    rd(6'h10, d); chk("R10", "empty set stays disarmed", d[0], 0);
    hw(CTL, 32'h8800);
    rd(CTL, d);   chk("R10", "quiesce clears state", d, 32'h02000000);
    chk("R10", "irq after quiesce", irq, 0);

    // stop and start
    hw(CTL, 32'h0400);
    hw(CTL, 32'h1000);
    rd(CTL, d); chk("R11", "stopped", d[0], 0);
    w0 = wcount;
    send(60, 6, 3'b0);
    chk("R11", "no writes while stopped", wcount - w0, 0);
    rd(CTL, d); chk("R7", "missed count while stopped", d[31:24], 3);
    hw(CTL, 32'h0400);
    w0 = wcount;
    send(61, 6, 3'b100);
    check_frame(32'h100 + 5 * 32, 6, 61, 3'b100, w0);
    rd(6'h08, d); chk("R11", "remaining after restart", d, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule